// File: doc/BRIEF.md
# Clock Synchronous Serial Port

This block moves bytes over a three-wire synchronous link: a shift clock, a data output and a data input. Transmit and receive always happen together, in full duplex, on one shift clock. The block can make that clock itself from a programmable divider, or it can follow a clock supplied by the link partner. A host loads a one-byte transmit buffer, and the buffer empties into a transmit shifter. In the same frame a receive shifter collects the incoming bits and hands the finished byte to a receive buffer.

Reception is tied to transmission. The shift clock only runs while the transmitter is enabled and holds a byte, so a host that only wants to receive must write a dummy byte. Flow control works on either side. A selectable clear-to-send input holds back the next frame. A ready-to-send output tells the partner whether an unread byte is still waiting in the receive buffer. Four flags report the state, and two sticky interrupt requests report transmit and receive progress.

Top module: `ssp_port`

## Requirements
- R1: Host map. Address 0 is data: a write fills the transmit buffer and a read returns the receive buffer. Address 1 is control: bit0 transmit enable, bit1 receive enable, bit2 external clock, bit3 polarity, bit4 flow control on, bit5 flow uses RTS (1) or CTS (0), bit6 transmit interrupt on shift done (1) or on buffer empty (0). Address 2 is the divider n. Address 3 is status: bit0 buffer empty, bit1 shifter empty, bit2 receive full, bit3 overrun, bit4 transmit interrupt, bit5 receive interrupt. After reset the status reads 0x03, the shift clock is at its idle level and txd_o is high.
- R2: A frame is 8 bits with no framing bits, sent least significant bit first. With polarity 0 the clock idles high, txd_o changes after a falling edge and rxd_i is sampled on the rising edge. With the internal clock and an idle port, a byte written in host write cycle W ends 1+16(n+1) cycles later. One clock period is 2(n+1) system cycles.
- R3: Polarity 1 makes the clock idle low, drives data on the rising edge and samples on the falling edge.
- R4: A waiting byte moves into the shifter as soon as the shifter is free and a start is allowed. At that point buffer empty sets, and the transmit interrupt sets if control bit6 is 0.
- R5: Shifter empty is 0 while a byte shifts or a byte waits. It becomes 1 only when the shift is done and the buffer is empty. With control bit6 = 1, the transmit interrupt sets at the end of a shift that leaves the buffer empty.
- R6: A new frame starts only while transmit is enabled and, when CTS flow control is selected, cts_n_i is low. A frame already in progress always completes, even if CTS goes high or transmit is disabled.
- R7: The clock does not run without transmit enable and a loaded byte. A received byte is kept only while receive enable is 1.
- R8: With RTS flow control selected, rts_n_o is high while an unread byte is held and goes low once it is read. Otherwise rts_n_o is low.
- R9: At the end of a frame the received byte goes to the receive buffer, and both receive full and the receive interrupt set. A data read clears receive full.
- R10: Overrun sets when a frame completes while receive full is 1 and no data read happens in that cycle. The new byte replaces the buffer. Writing receive enable = 0 clears overrun.
- R11: Both interrupt flags stay set until a status write with a 1 in bit4 (transmit) or bit5 (receive).
- R12: With the external clock, sclk_i passes through a two-flop synchronizer and is edge-detected. It must stay at or below a quarter of the system clock rate. Its edges drive the same shift rules as the internal clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Host write strobe |
| rd_en | input | 1 | Host read strobe |
| addr | input | 2 | Host register address |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data, follows addr |
| sclk_i | input | 1 | External shift clock |
| sclk_o | output | 1 | Internal shift clock |
| txd_o | output | 1 | Serial data out |
| rxd_i | input | 1 | Serial data in |
| cts_n_i | input | 1 | Clear to send, active low |
| rts_n_o | output | 1 | Ready to send, active low |
| irq_tx_o | output | 1 | Transmit interrupt request |
| irq_rx_o | output | 1 | Receive interrupt request |
| buf_empty_o | output | 1 | Transmit buffer empty |
| shift_empty_o | output | 1 | Transmit shifter empty |
| rx_full_o | output | 1 | Receive buffer full |
| overrun_o | output | 1 | Receive overrun |

## Verification
Two events can land in the same system cycle: a host read of the receive buffer, and the completion of the next frame. The bench writes a second byte while the first one is still unread. It then counts 16(n+1) cycles from the write, so that the data read strobe falls exactly in the cycle before the final sampling edge. The expected outcome is that the read returns the old byte and receive full stays set with the new byte. Overrun stays clear, because the old byte was consumed.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
    localparam logic [1:0] A_DATA = 2'd0;
    localparam logic [1:0] A_CTRL = 2'd1;
    localparam logic [1:0] A_DIV  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    // packed from MSB: irq_sel is bit6 ... tx_en is bit0
    typedef struct packed {
        logic irq_sel;
        logic flow_rts;
        logic flow_en;
        logic pol;
        logic ext_clk;
        logic rx_en;
        logic tx_en;
    } ctrl_t;
endpackage

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen #(
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ext_mode,
    input  logic             pol,
    input  logic [DIV_W-1:0] div,
    input  logic             sclk_i,
    output logic             lead,
    output logic             trail,
    output logic             sclk_o
);
    typedef struct packed {
        logic [DIV_W-1:0]  cnt;
        logic              phase;
        logic [SYNC_N-1:0] sync;
        logic              prev;
    } st_t;

    st_t st_d, st_q;
    logic tick, s_lvl, rise, fall;

    always_comb begin
        st_d      = st_q;
        tick      = 1'b0;
        st_d.sync = {st_q.sync[SYNC_N-2:0], sclk_i};
        st_d.prev = st_q.sync[SYNC_N-1];
        if (!run || ext_mode) begin
            st_d.cnt   = '0;
            st_d.phase = 1'b1;
        end else if (st_q.cnt == div) begin
            st_d.cnt   = '0;
            st_d.phase = ~st_q.phase;
            tick       = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    assign s_lvl  = st_q.sync[SYNC_N-1];
    assign rise   = s_lvl & ~st_q.prev;
    assign fall   = ~s_lvl & st_q.prev;
    assign lead   = run & (ext_mode ? (pol ? rise : fall) : (tick & st_q.phase));
    assign trail  = run & (ext_mode ? (pol ? fall : rise) : (tick & ~st_q.phase));
    assign sclk_o = st_q.phase ^ pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt   <= '0;
            st_q.phase <= 1'b1;
            st_q.sync  <= '0;
            st_q.prev  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: internal clock level only moves while a frame runs
    p_clk_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !ext_mode && $past(!run)) |-> $stable(sclk_o) || $changed(pol));
endmodule

// File: rtl/ssp_engine.sv
`timescale 1ns/1ps
module ssp_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              lead,
    input  logic              trail,
    input  logic              rxd,
    output logic              busy,
    output logic              done,
    output logic              txd,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

    typedef struct packed {
        logic              busy;
        logic [BW-1:0]     bitcnt;
        logic [DATA_W-1:0] tsh;
        logic [DATA_W-1:0] rsh;
        logic              txd;
    } st_t;

    st_t st_d, st_q;

    assign rx_byte = {rxd, st_q.rsh[DATA_W-1:1]};
    assign done    = st_q.busy & trail & (st_q.bitcnt == LAST);

    always_comb begin
        st_d = st_q;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy   = 1'b1;
                st_d.tsh    = tx_byte;
                st_d.bitcnt = '0;
                st_d.txd    = tx_byte[0];
            end
        end else begin
            if (lead) st_d.txd = st_q.tsh[st_q.bitcnt];
            if (trail) begin
                st_d.rsh = rx_byte;
                if (st_q.bitcnt == LAST) begin
                    st_d.busy   = 1'b0;
                    st_d.bitcnt = '0;
                    st_d.txd    = 1'b1;
                end else begin
                    st_d.bitcnt = st_q.bitcnt + 1'b1;
                end
            end
        end
    end

    assign busy = st_q.busy;
    assign txd  = st_q.txd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy   <= 1'b0;
            st_q.bitcnt <= '0;
            st_q.tsh    <= '0;
            st_q.rsh    <= '0;
            st_q.txd    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R7: clock edges reach the shifter only during a frame
    p_edges_in_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lead || trail) |-> st_q.busy);
    // R2: bit counter stays inside one frame
    p_bit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.busy |-> st_q.bitcnt == '0);
endmodule

// File: rtl/ssp_port.sv
`timescale 1ns/1ps
module ssp_port #(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              txd_o,
    input  logic              rxd_i,
    input  logic              cts_n_i,
    output logic              rts_n_o,
    output logic              irq_tx_o,
    output logic              irq_rx_o,
    output logic              buf_empty_o,
    output logic              shift_empty_o,
    output logic              rx_full_o,
    output logic              overrun_o
);
    import ssp_pkg::*;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DIV_W-1:0]  div;
        logic [DATA_W-1:0] txbuf;
        logic              txfull;
        logic [DATA_W-1:0] rxbuf;
        logic              rxfull;
        logic              ovr;
        logic              irq_tx;
        logic              irq_rx;
    } reg_t;

    reg_t r_d, r_q;
    logic busy, done, start, cts_ok, rd_data, lead, trail;
    logic [DATA_W-1:0] rx_byte;

    assign cts_ok  = !(r_q.ctrl.flow_en && !r_q.ctrl.flow_rts && cts_n_i);
    assign start   = r_q.txfull && r_q.ctrl.tx_en && cts_ok && !busy;
    assign rd_data = rd_en && (addr == A_DATA);

    ssp_clkgen #(.DIV_W(DIV_W), .SYNC_N(SYNC_N)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(busy), .ext_mode(r_q.ctrl.ext_clk),
        .pol(r_q.ctrl.pol), .div(r_q.div), .sclk_i(sclk_i),
        .lead(lead), .trail(trail), .sclk_o(sclk_o));

    ssp_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_byte(r_q.txbuf),
        .lead(lead), .trail(trail), .rxd(rxd_i), .busy(busy), .done(done),
        .txd(txd_o), .rx_byte(rx_byte));

    always_comb begin
        r_d = r_q;
        if (start) begin
            r_d.txfull = 1'b0;
            if (!r_q.ctrl.irq_sel) r_d.irq_tx = 1'b1;
        end
        if (wr_en) begin
            unique case (addr)
                A_DATA: begin r_d.txbuf = wdata; r_d.txfull = 1'b1; end
                A_CTRL: r_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
                A_DIV:  r_d.div  = wdata[DIV_W-1:0];
                A_STAT: begin
                    if (wdata[4]) r_d.irq_tx = 1'b0;
                    if (wdata[5]) r_d.irq_rx = 1'b0;
                end
            endcase
        end
        if (done && r_q.ctrl.irq_sel && !r_q.txfull) r_d.irq_tx = 1'b1;
        if (rd_data) r_d.rxfull = 1'b0;
        if (done && r_q.ctrl.rx_en) begin
            r_d.rxbuf  = rx_byte;
            r_d.rxfull = 1'b1;
            r_d.irq_rx = 1'b1;
            if (r_q.rxfull && !rd_data) r_d.ovr = 1'b1;
        end
        if (!r_d.ctrl.rx_en) r_d.ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (addr)
            A_DATA:  rdata = r_q.rxbuf;
            A_CTRL:  rdata = DATA_W'(r_q.ctrl);
            A_DIV:   rdata = DATA_W'(r_q.div);
            default: rdata = DATA_W'({r_q.irq_rx, r_q.irq_tx, r_q.ovr, r_q.rxfull,
                                      shift_empty_o, buf_empty_o});
        endcase
    end

    assign buf_empty_o   = !r_q.txfull;
    assign shift_empty_o = !busy && !r_q.txfull;
    assign rx_full_o     = r_q.rxfull;
    assign overrun_o     = r_q.ovr;
    assign irq_tx_o      = r_q.irq_tx;
    assign irq_rx_o      = r_q.irq_rx;
    assign rts_n_o       = r_q.ctrl.flow_en && r_q.ctrl.flow_rts && r_q.rxfull;

    p_start_tx_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(r_q.ctrl.tx_en));
    p_start_cts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !$past(r_q.ctrl.flow_en && !r_q.ctrl.flow_rts && cts_n_i));
    p_load_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> buf_empty_o || $past(wr_en && addr == A_DATA));
    p_ovr_needs_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ovr) |-> $past(r_q.rxfull));
    p_full_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.rxfull) |-> $past(busy) && !busy);
endmodule

// File: tb/sim_ssp_port.sv
`timescale 1ns/1ps
module sim_ssp_port;
    import ssp_pkg::*;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 0, rd_en = 0, sclk_i = 1'b1, cts_n_i = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0, rdata;
    logic sclk_o, txd_o, rts_n_o, irq_tx_o, irq_rx_o;
    logic buf_empty_o, shift_empty_o, rx_full_o, overrun_o;
    int total = 0, bad = 0;

    always #2.5 clk = ~clk;

    ssp_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .sclk_i(sclk_i), .sclk_o(sclk_o),
        .txd_o(txd_o), .rxd_i(txd_o), .cts_n_i(cts_n_i), .rts_n_o(rts_n_o),
        .irq_tx_o(irq_tx_o), .irq_rx_o(irq_rx_o), .buf_empty_o(buf_empty_o),
        .shift_empty_o(shift_empty_o), .rx_full_o(rx_full_o), .overrun_o(overrun_o));

    function automatic int frame_cycles(input int n);
        return 1 + 16 * (n + 1);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic xfer(input logic [7:0] b, output int cyc);
        wr(A_DATA, b);
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!shift_empty_o && cyc < 5000);
    endtask

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v, b, a;
        int cyc, n;
        void'($urandom(32'd1234));
        idle(3); rst_n = 1'b1; idle(2);
        // R1 reset state
        rd(A_STAT, v); chk("R1 status", v, 8'h03);
        chk("R1 txd", txd_o, 1'b1);
        chk("R2 idle clk", sclk_o, 1'b1);
        chk("R8 rts", rts_n_o, 1'b0);

        wr(A_CTRL, 8'h03);
        for (int i = 0; i < 8; i++) begin
            n = (i == 0) ? 0 : int'($urandom % 6);
            b = (i == 1) ? 8'h01 : (i == 2) ? 8'h80 : 8'($urandom);
            wr(A_DIV, 8'(n));
            wr(A_STAT, 8'h30);
            xfer(b, cyc);
            chk("R2 frame length", cyc, frame_cycles(n));
            chk("R4 irq_tx", irq_tx_o, 1'b1);
            chk("R9 irq_rx", irq_rx_o, 1'b1);
            rd(A_DATA, v);
            chk("R2 loopback data", v, b);
            chk("R9 full cleared", rx_full_o, 1'b0);
        end
        wr(A_STAT, 8'h30);
        chk("R11 irq cleared", {irq_tx_o, irq_rx_o}, 2'b00);

        // R5 shifter empty mid-frame, irq on shift done
        wr(A_DIV, 8'd2); wr(A_CTRL, 8'h43);
        wr(A_DATA, 8'h5A); idle(5);
        chk("R5 shift busy", {shift_empty_o, buf_empty_o}, 2'b01);
        chk("R5 irq not yet", irq_tx_o, 1'b0);
        idle(60);
        chk("R5 irq at end", {irq_tx_o, shift_empty_o}, 2'b11);
        rd(A_DATA, v); wr(A_STAT, 8'h30);

        // R3 polarity 1
        wr(A_CTRL, 8'h0B); idle(2);
        chk("R3 idle low", sclk_o, 1'b0);
        xfer(8'hC3, cyc); rd(A_DATA, v);
        chk("R3 data", v, 8'hC3);
        chk("R3 length", cyc, frame_cycles(2));

        // R7 no clock without tx enable
        wr(A_CTRL, 8'h02); wr(A_DATA, 8'h11); idle(60);
        chk("R7 held", {buf_empty_o, rx_full_o, sclk_o}, 3'b001);
        // R6 tx disable mid-frame finishes current byte only
        wr(A_CTRL, 8'h03); idle(4);
        wr(A_DATA, 8'h22); wr(A_CTRL, 8'h02); idle(60);
        rd(A_DATA, v); chk("R6 frame completed", v, 8'h11);
        chk("R6 next held", buf_empty_o, 1'b0);
        // R7 no capture with receive disabled
        wr(A_CTRL, 8'h01); idle(60);
        chk("R7 no capture", {buf_empty_o, rx_full_o}, 2'b10);

        // R6 CTS
        wr(A_CTRL, 8'h13); cts_n_i = 1'b1;
        wr(A_DATA, 8'h3C); idle(60);
        chk("R6 cts blocks", buf_empty_o, 1'b0);
        cts_n_i = 1'b0; idle(6);
        wr(A_DATA, 8'h99); cts_n_i = 1'b1; idle(70);
        rd(A_DATA, v); chk("R6 cts frame", v, 8'h3C);
        chk("R6 cts next waits", buf_empty_o, 1'b0);
        cts_n_i = 1'b0; idle(70);
        rd(A_DATA, v); chk("R6 cts resume", v, 8'h99);

        // R8 RTS
        wr(A_CTRL, 8'h33); xfer(8'h47, cyc);
        chk("R8 rts high", rts_n_o, 1'b1);
        rd(A_DATA, v); chk("R8 rts low", rts_n_o, 1'b0);

        // R10 overrun and clear
        wr(A_CTRL, 8'h03); xfer(8'hA1, cyc); xfer(8'hB2, cyc);
        chk("R10 overrun", overrun_o, 1'b1);
        rd(A_DATA, v); chk("R10 replaced", v, 8'hB2);
        wr(A_CTRL, 8'h01); chk("R10 cleared", overrun_o, 1'b0);

        // collision: read in the cycle the next frame ends
        wr(A_CTRL, 8'h03); n = 2;
        xfer(8'h6D, cyc);
        wr(A_DATA, 8'hE4);
        repeat (16 * (n + 1) - 1) @(negedge clk);
        @(negedge clk); addr = A_DATA; rd_en = 1'b1; #1 a = rdata;
        @(negedge clk); rd_en = 1'b0;
        chk("R10 collide old byte", a, 8'h6D);
        chk("R10 collide flags", {rx_full_o, overrun_o}, 2'b10);
        rd(A_DATA, v); chk("R9 collide new byte", v, 8'hE4);

        // R12 external clock
        wr(A_CTRL, 8'h07); wr(A_DATA, 8'h96); idle(3);
        for (int k = 0; k < 8; k++) begin
            sclk_i = 1'b0; idle(4); sclk_i = 1'b1; idle(4);
        end
        idle(5);
        chk("R12 ext done", {rx_full_o, shift_empty_o}, 2'b11);
        rd(A_DATA, v); chk("R12 ext data", v, 8'h96);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule